// File: doc/BRIEF.md
# Hysteretic Gain Control Loop

This block closes the digital half of an automatic gain loop in front of an ADC. It takes the signed conversion stream, forms the magnitude of each accepted sample, and sums the magnitudes over a fixed window of 2^N samples. At the end of each window the truncated mean magnitude is compared against a configurable target level, with a configurable dead band on either side of it. A mean above the band steps the amplifier gain code down by one. A mean below the band steps it up by one. A mean inside the band leaves it where it is.

The gain code is an integrator that saturates at both ends. Its width matches the number of amplifier gain settings, so the code can drive the amplifier's gain select directly. A one-cycle strobe marks every decision, including decisions that leave the code unchanged, so that downstream logic can follow the loop's pace.

Top module: `gain_servo`

## Requirements
- R1: The magnitude of an accepted sample is its absolute value. The most negative two's-complement code (-2^(SAMPLE_W-1)) is clamped to the largest positive code, 2^(SAMPLE_W-1)-1.
- R2: A decision is made once for every 2^N accepted samples. A sample is accepted only in a cycle with `smp_valid` high. Cycles with `smp_valid` low leave the window count and the running sum unchanged, whatever `smp_data` carries.
- R3: The mean used for a decision is the sum of the window's 2^N magnitudes divided by 2^N and rounded down. The running sum then restarts from zero for the next window.
- R4: When the mean exceeds `level_target + level_hyst`, the gain code decreases by one.
- R5: When `mean + level_hyst` is smaller than `level_target`, the gain code increases by one.
- R6: When the mean lies inside the band (both edges included), the gain code holds.
- R7: The gain code saturates at 0 and at 2^GAIN_W-1 and never wraps.
- R8: After reset the gain code is mid-scale, 2^(GAIN_W-1) (16 by default), the strobe is low and the window is empty.
- R9: `gain_strobe` is high for exactly one cycle. It rises two clock edges after the edge that accepts the window's last sample, and the new gain code appears in that same cycle.
- R10: The gain code changes only in a strobe cycle, and by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Marks `smp_data` as a sample to accept |
| smp_data | input | SAMPLE_W | Signed ADC sample, two's complement |
| level_target | input | SAMPLE_W-1 | Target mean magnitude |
| level_hyst | input | SAMPLE_W-1 | Half-width of the dead band around the target |
| gain_code | output | GAIN_W | Amplifier gain select |
| gain_strobe | output | 1 | One-cycle pulse for each decision |

## Verification
Every cycle, the assertions check the properties that can be stated locally. The gain code moves by at most one step, and only when a decision is made. It holds at either rail when pushed further, never wrapping. Decision pulses are never adjacent. The most negative sample is clamped. The bench scenarios are needed for the arithmetic across a whole window: the floor of the mean, the exact band edges, the skipping of idle cycles, the two-edge latency, and the walk of the code to each rail over many windows.

// File: rtl/gs_pkg.sv
package gs_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/gs_magnitude.sv
module gs_magnitude #(
    parameter int SAMPLE_W = 10,
    parameter int MAG_W    = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                mag_valid,
    output logic [MAG_W-1:0]    mag
);
    localparam logic [MAG_W-1:0]    MAG_MAX = '1;
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic [MAG_W-1:0] mag;
    } mag_st_t;

    mag_st_t st_d, st_q;
    logic [SAMPLE_W-1:0] negated;

    always_comb begin
        negated   = ~in_sample + 1'b1;
        st_d      = st_q;
        st_d.vld  = in_valid;
        if (in_valid) begin
            if (!in_sample[SAMPLE_W-1])
                st_d.mag = in_sample[MAG_W-1:0];
            else if (negated[SAMPLE_W-1])
                st_d.mag = MAG_MAX;
            else
                st_d.mag = negated[MAG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mag_valid = st_q.vld;
    assign mag       = st_q.mag;

    // R1
    most_neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(in_sample) == MOST_NEG) |-> (mag_valid && mag == MAG_MAX));
endmodule

// File: rtl/gs_window_avg.sv
module gs_window_avg #(
    parameter int MAG_W    = 9,
    parameter int WIN_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mag_valid,
    input  logic [MAG_W-1:0] mag,
    output logic             avg_valid,
    output logic [MAG_W-1:0] avg
);
    localparam int ACC_W = MAG_W + WIN_LOG2;
    localparam logic [WIN_LOG2-1:0] LAST = '1;

    typedef struct packed {
        logic [WIN_LOG2-1:0] cnt;
        logic [ACC_W-1:0]    acc;
        logic [MAG_W-1:0]    avg;
        logic                vld;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        sum      = st_q.acc + ACC_W'(mag);
        if (mag_valid) begin
            if (st_q.cnt == LAST) begin
                st_d.avg = sum[ACC_W-1:WIN_LOG2];
                st_d.vld = 1'b1;
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = sum;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg_valid = st_q.vld;
    assign avg       = st_q.avg;

    // R2
    avg_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> !avg_valid);

    // R2
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mag_valid) |-> ($stable(st_q.cnt) && $stable(st_q.acc)));
endmodule

// File: rtl/gs_hyst_step.sv
module gs_hyst_step
    import gs_pkg::*;
#(
    parameter int MAG_W  = 9,
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              avg_valid,
    input  logic [MAG_W-1:0]  avg,
    input  logic [MAG_W-1:0]  target,
    input  logic [MAG_W-1:0]  hyst,
    output logic [GAIN_W-1:0] gain,
    output logic              strobe
);
    localparam logic [GAIN_W-1:0] GAIN_MAX = '1;
    localparam logic [GAIN_W-1:0] GAIN_MID = {1'b1, {(GAIN_W-1){1'b0}}};

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              stb;
    } gain_st_t;

    gain_st_t st_d, st_q;
    step_e    dir;
    logic [MAG_W:0] upper_edge;
    logic [MAG_W:0] lifted_avg;

    always_comb begin
        upper_edge = {1'b0, target} + {1'b0, hyst};
        lifted_avg = {1'b0, avg} + {1'b0, hyst};
        if ({1'b0, avg} > upper_edge)       dir = STEP_DOWN;
        else if (lifted_avg < {1'b0, target}) dir = STEP_UP;
        else                                 dir = STEP_HOLD;
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = avg_valid;
        if (avg_valid) begin
            unique case (dir)
                STEP_UP:   if (st_q.gain != GAIN_MAX) st_d.gain = st_q.gain + 1'b1;
                STEP_DOWN: if (st_q.gain != '0)       st_d.gain = st_q.gain - 1'b1;
                default:   st_d.gain = st_q.gain;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gain <= GAIN_MID;
            st_q.stb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain   = st_q.gain;
    assign strobe = st_q.stb;

    // R10
    gain_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == $past(gain)) || (gain == $past(gain) + 1'b1) || (gain == $past(gain) - 1'b1));

    // R10
    gain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> $stable(gain));

    // R7
    top_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gain) == GAIN_MAX) |-> (gain != '0));

    // R7
    bottom_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gain) == '0) |-> (gain != GAIN_MAX));

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/gain_servo.sv
module gain_servo #(
    parameter int SAMPLE_W = 10,
    parameter int WIN_LOG2 = 8,
    parameter int GAIN_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-2:0] level_target,
    input  logic [SAMPLE_W-2:0] level_hyst,
    output logic [GAIN_W-1:0]   gain_code,
    output logic                gain_strobe
);
    localparam int MAG_W = SAMPLE_W - 1;

    logic             mag_vld;
    logic [MAG_W-1:0] mag_val;
    logic             avg_vld;
    logic [MAG_W-1:0] avg_val;

    gs_magnitude #(.SAMPLE_W(SAMPLE_W), .MAG_W(MAG_W)) u_mag (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_sample (smp_data),
        .mag_valid (mag_vld),
        .mag       (mag_val)
    );

    gs_window_avg #(.MAG_W(MAG_W), .WIN_LOG2(WIN_LOG2)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .mag_valid (mag_vld),
        .mag       (mag_val),
        .avg_valid (avg_vld),
        .avg       (avg_val)
    );

    gs_hyst_step #(.MAG_W(MAG_W), .GAIN_W(GAIN_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .avg_valid (avg_vld),
        .avg       (avg_val),
        .target    (level_target),
        .hyst      (level_hyst),
        .gain      (gain_code),
        .strobe    (gain_strobe)
    );
endmodule

// File: tb/gain_servo_test.sv
`timescale 1ns/1ps
module gain_servo_test;
    localparam int SW   = 10;
    localparam int NL   = 8;
    localparam int GW   = 5;
    localparam int WIN  = 1 << NL;
    localparam int MAGX = (1 << (SW - 1)) - 1;
    localparam int GMAX = (1 << GW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [SW-2:0] level_target = '0;
    logic [SW-2:0] level_hyst = '0;
    logic [GW-1:0] gain_code;
    logic          gain_strobe;

    int tests = 0;
    int fails = 0;
    int model_gain = 1 << (GW - 1);
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gain_servo #(.SAMPLE_W(SW), .WIN_LOG2(NL), .GAIN_W(GW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .level_target (level_target),
        .level_hyst   (level_hyst),
        .gain_code    (gain_code),
        .gain_strobe  (gain_strobe)
    );

    function automatic int mag_of(int v);
        int m = (v < 0) ? -v : v;
        return (m > MAGX) ? MAGX : m;
    endfunction

    function automatic int step_gain(int g, int avg, int tgt, int hy);
        if (avg > tgt + hy)      return (g == 0) ? 0 : g - 1;
        else if (avg + hy < tgt) return (g == GMAX) ? GMAX : g + 1;
        return g;
    endfunction

    task automatic check(string req, int actual, int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // mode 0: constant base; 1: full-range random; 2: random within base +/- 8;
    // 3: alternating base / base+1 (sum not a multiple of the window)
    task automatic run_window(int tgt, int hy, int mode, int base, bit idles, string req);
        int sum = 0;
        int v = 0;
        int avg;
        level_target = SW'(tgt) & MAGX;
        level_hyst   = SW'(hy) & MAGX;
        for (int i = 0; i < WIN; i++) begin
            // R2: idle cycles with garbage data must not be counted
            if (idles && ($urandom % 4 == 0)) begin
                @(negedge clk);
                smp_valid = 1'b0;
                smp_data  = SW'($urandom);
                @(posedge clk);
            end
            case (mode)
                0: v = base;
                1: v = int'($signed(SW'($urandom)));
                2: v = base + int'($urandom % 17) - 8;
                default: v = base + (i % 2);
            endcase
            if (v < -(MAGX + 1)) v = -(MAGX + 1);
            if (v > MAGX) v = MAGX;
            if (($urandom % 2 == 1) && mode != 3) v = -v;
            sum += mag_of(v);
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = SW'(v);
            @(posedge clk);
        end
        avg = sum >> NL;
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = SW'($urandom);
        @(posedge clk);
        #1;
        check({req, "/R9 no strobe yet"}, int'(gain_strobe), 0);
        check({req, "/R10 gain before strobe"}, int'(gain_code), model_gain);
        model_gain = step_gain(model_gain, avg, tgt, hy);
        @(posedge clk);
        #1;
        check({req, "/R9 strobe"}, int'(gain_strobe), 1);
        check(req, int'(gain_code), model_gain);
        @(posedge clk);
        #1;
        check({req, "/R9 single pulse"}, int'(gain_strobe), 0);
    endtask

    initial begin
        #900000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset gain", int'(gain_code), 1 << (GW - 1));
        check("R8 reset strobe", int'(gain_strobe), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R8 idle after reset", int'(gain_code), 1 << (GW - 1));

        // R1: most negative code clamps to 511 -> mean 511 > 200+10 -> down
        run_window(200, 10, 0, -(MAGX + 1), 1'b0, "R1 R4 clamp");
        // R1: plain negative value -300 -> mean 300
        run_window(300, 0, 0, -300, 1'b0, "R1 negative");
        // R6 band edges, inclusive
        run_window(100, 20, 0, 120, 1'b0, "R6 upper edge");
        run_window(100, 20, 0, 80, 1'b0, "R6 lower edge");
        run_window(100, 20, 0, 121, 1'b0, "R4 just above");
        run_window(100, 20, 0, 79, 1'b0, "R5 just below");
        // R3: alternating 50/51 -> sum 256*50+128 -> mean floors to 50
        run_window(51, 0, 3, 50, 1'b0, "R3 floor");
        // R3: window restarts, constant 51 -> hold
        run_window(51, 0, 0, 51, 1'b1, "R3 restart R2 idles");
        // R7: drive to the bottom rail and hold there
        for (int k = 0; k < 20; k++) run_window(10, 2, 0, 400, k[0], "R7 floor");
        check("R7 at zero", int'(gain_code), 0);
        // R7: drive to the top rail and hold there
        for (int k = 0; k < 36; k++) run_window(300, 5, 0, 0, k[0], "R7 ceiling");
        check("R7 at max", int'(gain_code), GMAX);
        // random mix
        for (int k = 0; k < 50; k++) begin
            int tgt = int'($urandom % (MAGX + 1));
            int hy  = int'($urandom % 40);
            if (k % 2 == 0)
                run_window(tgt, hy, 2, tgt, 1'b1, "R2 R4 R5 R6 random band");
            else
                run_window(tgt, hy, 1, 0, 1'b1, "R4 R5 random full");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule